// File: doc/BRIEF.md
# UART Register Front End

This block is the software-facing side of a simple 8-bit UART. A host reaches it through a word-addressed register bus with a write strobe and a combinational read path. It turns accesses into push and pop strobes for the transmit and receive queues, and it holds the line configuration that the serializer core uses. It also latches interrupt causes, masks them and drives one host interrupt line.

Characters move through one data register. On a read, two flag bits report whether a received character is waiting and whether the transmitter can take another one. On a write, the same two flags say whether to send the low byte or to discard the waiting received byte. The control/status word holds the parity, interface-mode, break and host-interrupt-enable settings. It also reports two read-only bits: transmitter busy and the masked interrupt summary. Software reads that summary before it looks at the individual causes.

Top module: `uart_regif`

## Requirements
- R1: After reset, all of these read as zero: control/status (byte offset 0x4), clock (0x8), interrupt status (0xC) and interrupt enable (0x10). After reset host_irq, line_break, uart_en and parity_en are 0.
- R2: A read of the data register (offset 0x0) returns the following: bits [7:0] hold rxq_data when the receive queue is non-empty and 0 otherwise, bit 8 (RX flag) is 1 when the receive queue is non-empty, and bit 9 (TX flag) is 1 when the transmit queue is not full.
- R3: A data-register write with bit 9 set raises txq_push in the same cycle, with txq_data equal to bits [7:0], but only when txq_full is 0. When the queue is full the character is dropped.
- R4: A data-register write with bit 8 set and bit 9 clear raises rxq_pop in the same cycle if the receive queue is non-empty. Any other data write never pops.
- R5: Interrupt status (offset 0xC; bit 0 is RX-valid, bit 1 is TX-empty) is write-one-to-clear. A hardware set in the same cycle as a clear of that bit wins.
- R6: RX-valid is set at every clock in which the receive queue is non-empty. TX-empty is set once when txq_empty goes from 0 to 1.
- R7: Interrupt enable (offset 0x10) keeps bits [1:0], which line up with the status bits. Control/status bit 7 is the read-only OR of status AND enable.
- R8: host_irq is 1 exactly when control/status bit 7 is 1 and the host-interrupt-enable bit 5 is set.
- R9: Control/status bits [1:0] set parity: 00 is none, 01 is odd, 10 is even, and 11 acts as none. Bits [3:2] set the interface mode: 00 disables the UART (uart_en=0) and any other value enables it. Bit 4 drives line_break. Bits [5:0] read back as written.
- R10: Control/status bit 6 is the read-only value core_busy OR NOT txq_empty. Writes to bits 6 and 7 have no effect.
- R11: The clock register (offset 0x8) stores and returns all 32 bits and drives clk_cfg.
- R12: Offsets 0x14 to 0x1C, and any address whose low two bits are not zero, read as 0. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| txq_push | output | 1 | Enqueue txq_data into the transmit queue |
| txq_data | output | 8 | Character to enqueue |
| txq_full | input | 1 | Transmit queue full |
| txq_empty | input | 1 | Transmit queue empty |
| rxq_pop | output | 1 | Discard the head of the receive queue |
| rxq_data | input | 8 | Head of the receive queue |
| rxq_empty | input | 1 | Receive queue empty |
| core_busy | input | 1 | Serializer is still shifting a character |
| parity_en | output | 1 | Parity bit generated and checked |
| parity_odd | output | 1 | Odd parity when parity_en is set |
| uart_en | output | 1 | Interface mode is not zero |
| line_break | output | 1 | Force the transmit line into break |
| clk_cfg | output | 32 | Baud configuration word |
| host_irq | output | 1 | Host interrupt |

## Verification
Two events can land on the RX-valid status bit in the same cycle: the receive queue is non-empty, which sets it, and software writes a 1 to that bit, which clears it. The bench provokes this by holding rxq_empty low during the very cycle in which it writes 0x1 to the status register. It then expects the bit to read 1 afterwards. A second clear, with the queue empty, must leave it at 0. The same test is repeated on the data register, where a write carrying both flags must push and must not pop.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;
  // word indices (byte offset / 4)
  localparam int W_DATA = 0;
  localparam int W_CSR  = 1;
  localparam int W_CLK  = 2;
  localparam int W_IST  = 3;
  localparam int W_IEN  = 4;
  localparam int N_WORDS = 5;

  // interrupt cause bits
  localparam int IRQ_RX = 0;
  localparam int IRQ_TX = 1;
  localparam int N_IRQ  = 2;

  // writable part of control/status, LSB first: par[1:0], mode[3:2], brk 4, hie 5
  localparam int CSR_RW_W = 6;

  typedef struct packed {
    logic       hie;
    logic       brk;
    logic [1:0] mode;
    logic [1:0] par;
  } csr_t;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_ODD  = 2'b01,
    PAR_EVEN = 2'b10,
    PAR_RSVD = 2'b11
  } par_e;
endpackage

// File: rtl/uart_regif_decode.sv
module uart_regif_decode #(
  parameter int ADDR_W  = 5,
  parameter int N_WORDS = 5
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [N_WORDS-1:0] sel
);
  localparam int IDX_W = ADDR_W - 2;

  logic aligned;
  assign aligned = (addr[1:0] == 2'b00);

  for (genvar i = 0; i < N_WORDS; i++) begin : g_sel
    assign sel[i] = aligned && (addr[ADDR_W-1:2] == IDX_W'(i));
  end
endmodule

// File: rtl/uart_regif_irq.sv
module uart_regif_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_mask,
  input  logic         ien_wr,
  input  logic [N-1:0] ien_wdata,
  output logic [N-1:0] ist_q,
  output logic [N-1:0] ien_q,
  output logic         pending
);
  logic [N-1:0] ist_d;
  logic [N-1:0] ien_d;

  for (genvar i = 0; i < N; i++) begin : g_bit
    // hardware set dominates a software clear in the same cycle
    assign ist_d[i] = set[i] | (ist_q[i] & ~(clr_wr & clr_mask[i]));
  end

  always_comb begin
    ien_d = ien_q;
    if (ien_wr) ien_d = ien_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ist_q <= '0;
      ien_q <= '0;
    end else begin
      ist_q <= ist_d;
      ien_q <= ien_d;
    end
  end

  assign pending = |(ist_q & ien_q);
endmodule

// File: rtl/uart_regif_ctl.sv
module uart_regif_ctl
  import uart_regif_pkg::*;
#(
  parameter int CLK_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                csr_wr,
  input  logic [CSR_RW_W-1:0] csr_wdata,
  input  logic                clk_wr,
  input  logic [CLK_W-1:0]    clk_wdata,
  output csr_t                csr_q,
  output logic [CLK_W-1:0]    clk_q
);
  csr_t             csr_d;
  logic [CLK_W-1:0] clk_d;

  always_comb begin
    csr_d = csr_q;
    clk_d = clk_q;
    if (csr_wr) csr_d = csr_t'(csr_wdata);
    if (clk_wr) clk_d = clk_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_q <= '0;
      clk_q <= '0;
    end else begin
      csr_q <= csr_d;
      clk_q <= clk_d;
    end
  end
endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CHAR_W = 8,
  parameter int CLK_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              txq_push,
  output logic [CHAR_W-1:0] txq_data,
  input  logic              txq_full,
  input  logic              txq_empty,
  output logic              rxq_pop,
  input  logic [CHAR_W-1:0] rxq_data,
  input  logic              rxq_empty,
  input  logic              core_busy,
  output logic              parity_en,
  output logic              parity_odd,
  output logic              uart_en,
  output logic              line_break,
  output logic [CLK_W-1:0]  clk_cfg,
  output logic              host_irq
);
  localparam int RX_FLAG = CHAR_W;
  localparam int TX_FLAG = CHAR_W + 1;

  logic [N_WORDS-1:0] sel;
  csr_t               csr_q;
  logic [N_IRQ-1:0]   ist_q;
  logic [N_IRQ-1:0]   ien_q;
  logic [N_IRQ-1:0]   irq_set;
  logic               pending;
  logic               tx_busy;
  logic               host_en;
  logic               txe_prev_q;
  logic               txe_prev_d;
  logic               data_wr;

  uart_regif_decode #(.ADDR_W(ADDR_W), .N_WORDS(N_WORDS)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  uart_regif_ctl #(.CLK_W(CLK_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_wr    (bus_wr && sel[W_CSR]),
    .csr_wdata (bus_wdata[CSR_RW_W-1:0]),
    .clk_wr    (bus_wr && sel[W_CLK]),
    .clk_wdata (bus_wdata[CLK_W-1:0]),
    .csr_q     (csr_q),
    .clk_q     (clk_cfg)
  );

  // transmit-drain edge: txq_empty rising
  assign txe_prev_d = txq_empty;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) txe_prev_q <= 1'b1;
    else        txe_prev_q <= txe_prev_d;
  end

  assign irq_set[IRQ_RX] = ~rxq_empty;
  assign irq_set[IRQ_TX] = txq_empty & ~txe_prev_q;

  uart_regif_irq #(.N(N_IRQ)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .set       (irq_set),
    .clr_wr    (bus_wr && sel[W_IST]),
    .clr_mask  (bus_wdata[N_IRQ-1:0]),
    .ien_wr    (bus_wr && sel[W_IEN]),
    .ien_wdata (bus_wdata[N_IRQ-1:0]),
    .ist_q     (ist_q),
    .ien_q     (ien_q),
    .pending   (pending)
  );

  // data register handshake
  assign data_wr  = bus_wr && sel[W_DATA];
  assign txq_push = data_wr && bus_wdata[TX_FLAG] && !txq_full;
  assign txq_data = bus_wdata[CHAR_W-1:0];
  assign rxq_pop  = data_wr && bus_wdata[RX_FLAG] && !bus_wdata[TX_FLAG] && !rxq_empty;

  // configuration outputs
  assign parity_en  = (csr_q.par == PAR_ODD) || (csr_q.par == PAR_EVEN);
  assign parity_odd = (csr_q.par == PAR_ODD);
  assign uart_en    = (csr_q.mode != 2'b00);
  assign line_break = csr_q.brk;
  assign host_en    = csr_q.hie;
  assign tx_busy    = core_busy | ~txq_empty;
  assign host_irq   = pending & host_en;

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (sel[W_DATA]) begin
      bus_rdata[CHAR_W-1:0] = rxq_empty ? '0 : rxq_data;
      bus_rdata[RX_FLAG]    = ~rxq_empty;
      bus_rdata[TX_FLAG]    = ~txq_full;
    end
    if (sel[W_CSR]) bus_rdata = DATA_W'({pending, tx_busy, csr_q});
    if (sel[W_CLK]) bus_rdata = DATA_W'(clk_cfg);
    if (sel[W_IST]) bus_rdata = DATA_W'(ist_q);
    if (sel[W_IEN]) bus_rdata = DATA_W'(ien_q);
  end
endmodule

// File: rtl/uart_regif_chk.sv
module uart_regif_chk #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int CLK_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              txq_push,
  input logic              txq_full,
  input logic              rxq_pop,
  input logic              rxq_empty,
  input logic [1:0]        ist_q,
  input logic              host_en,
  input logic              host_irq,
  input logic              line_break,
  input logic [CLK_W-1:0]  clk_cfg
);
  p_push_safe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    txq_push |-> !txq_full);

  p_pop_safe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rxq_pop |-> (!rxq_empty && !txq_push));

  p_stat_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(12) && bus_wdata[0] && rxq_empty) |=> !ist_q[0]);

  p_rx_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rxq_empty |=> ist_q[0]);

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> host_en);

  p_break_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == ADDR_W'(4)) |=> $stable(line_break));

  p_clk_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == ADDR_W'(8)) |=> $stable(clk_cfg));
endmodule

bind uart_regif uart_regif_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_W(CLK_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_wr     (bus_wr),
  .bus_wdata  (bus_wdata),
  .txq_push   (txq_push),
  .txq_full   (txq_full),
  .rxq_pop    (rxq_pop),
  .rxq_empty  (rxq_empty),
  .ist_q      (ist_q),
  .host_en    (host_en),
  .host_irq   (host_irq),
  .line_break (line_break),
  .clk_cfg    (clk_cfg)
);

// File: tb/uart_regif_bench.sv
module uart_regif_bench;
  logic        clk;
  logic        rst_n;
  logic [4:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        txq_push;
  logic [7:0]  txq_data;
  logic        txq_full;
  logic        txq_empty;
  logic        rxq_pop;
  logic [7:0]  rxq_data;
  logic        rxq_empty;
  logic        core_busy;
  logic        parity_en;
  logic        parity_odd;
  logic        uart_en;
  logic        line_break;
  logic [31:0] clk_cfg;
  logic        host_irq;

  int total = 0;
  int bad   = 0;
  logic        smp_push;
  logic        smp_pop;
  logic [7:0]  smp_data;
  logic [31:0] rd;

  uart_regif u_uart_regif (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .txq_push(txq_push),
    .txq_data(txq_data), .txq_full(txq_full), .txq_empty(txq_empty),
    .rxq_pop(rxq_pop), .rxq_data(rxq_data), .rxq_empty(rxq_empty),
    .core_busy(core_busy), .parity_en(parity_en), .parity_odd(parity_odd),
    .uart_en(uart_en), .line_break(line_break), .clk_cfg(clk_cfg),
    .host_irq(host_irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {addr, write data, expected readback}
  localparam logic [68:0] VEC [10] = '{
    {5'h04, 32'h0000_003F, 32'h0000_003F},
    {5'h04, 32'hFFFF_FFC0, 32'h0000_0000},
    {5'h08, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {5'h08, 32'h0001_2345, 32'h0001_2345},
    {5'h10, 32'hFFFF_FFFF, 32'h0000_0003},
    {5'h10, 32'h0000_0000, 32'h0000_0000},
    {5'h14, 32'hFFFF_FFFF, 32'h0000_0000},
    {5'h1C, 32'h0000_0012, 32'h0000_0000},
    {5'h09, 32'h0000_0055, 32'h0000_0000},
    {5'h0C, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  function automatic string vec_req(int i);
    case (i)
      0, 1:    return "R9";
      2, 3:    return "R11";
      4, 5:    return "R7";
      9:       return "R5";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    #1;
    smp_push = txq_push;
    smp_pop  = rxq_pop;
    smp_data = txq_data;
    @(posedge clk);
    #1;
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_wr   = 1'b0;
    #1;
    d = bus_rdata;
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    txq_full = 1'b0; txq_empty = 1'b1; rxq_data = 8'h00; rxq_empty = 1'b1;
    core_busy = 1'b0;
    smp_push = 1'b0; smp_pop = 1'b0; smp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_read(5'h04, rd); check("R1 csr", rd, 32'h0);
    bus_read(5'h08, rd); check("R1 clk", rd, 32'h0);
    bus_read(5'h0C, rd); check("R1 ist", rd, 32'h0);
    bus_read(5'h10, rd); check("R1 ien", rd, 32'h0);
    check("R1 outputs", {28'h0, host_irq, line_break, uart_en, parity_en}, 32'h0);

    // register table
    for (int i = 0; i < 10; i++) begin
      bus_write(VEC[i][68:64], VEC[i][63:32]);
      bus_read(VEC[i][68:64], rd);
      check(vec_req(i), rd, VEC[i][31:0]);
    end
    bus_read(5'h08, rd); check("R12 clk untouched", rd, 32'h0001_2345);

    // R2 data read flags
    rxq_data = 8'h5A; rxq_empty = 1'b0; txq_full = 1'b0;
    bus_read(5'h00, rd); check("R2 data full flags", rd, 32'h0000_035A);
    rxq_empty = 1'b1; txq_full = 1'b1;
    bus_read(5'h00, rd); check("R2 data no flags", rd, 32'h0);

    // R3 push
    txq_full = 1'b0;
    bus_write(5'h00, 32'h241);
    check("R3 push", {23'h0, smp_push, smp_data}, {23'h0, 1'b1, 8'h41});
    txq_full = 1'b1;
    bus_write(5'h00, 32'h242);
    check("R3 push when full", {31'h0, smp_push}, 32'h0);
    txq_full = 1'b0;

    // R4 pop
    rxq_empty = 1'b0;
    bus_write(5'h00, 32'h100);
    check("R4 pop", {30'h0, smp_pop, smp_push}, 32'h2);
    bus_write(5'h00, 32'h3C3);
    check("R4 both flags push only", {30'h0, smp_pop, smp_push}, 32'h1);
    rxq_empty = 1'b1;
    bus_write(5'h00, 32'h100);
    check("R4 pop when empty", {31'h0, smp_pop}, 32'h0);

    // R5/R6 rx-valid set, clear, and collision
    bus_write(5'h0C, 32'h3);
    bus_read(5'h0C, rd); check("R5 cleared", rd, 32'h0);
    @(negedge clk); rxq_empty = 1'b0;
    @(negedge clk); rxq_empty = 1'b1;
    bus_read(5'h0C, rd); check("R6 rx set", rd, 32'h1);
    @(negedge clk);
    rxq_empty = 1'b0; bus_addr = 5'h0C; bus_wdata = 32'h1; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0; rxq_empty = 1'b1;
    bus_read(5'h0C, rd); check("R5 set wins over clear", rd, 32'h1);
    bus_write(5'h0C, 32'h1);
    bus_read(5'h0C, rd); check("R5 clear", rd, 32'h0);

    // R6 tx-empty edge, R10 busy
    @(negedge clk); txq_empty = 1'b0;
    bus_read(5'h04, rd); check("R10 busy from queue", rd & 32'h40, 32'h40);
    @(negedge clk); txq_empty = 1'b1;
    bus_read(5'h0C, rd); check("R6 tx empty set", rd, 32'h2);
    bus_write(5'h0C, 32'h2);
    bus_read(5'h0C, rd); check("R6 no resets without edge", rd, 32'h0);
    core_busy = 1'b1;
    bus_write(5'h04, 32'hC0);
    bus_read(5'h04, rd); check("R10 busy from core, ro bits", rd, 32'h40);
    core_busy = 1'b0;

    // R7/R8 interrupt masking
    @(negedge clk); rxq_empty = 1'b0;
    @(negedge clk); rxq_empty = 1'b1;
    bus_write(5'h10, 32'h1);
    bus_read(5'h04, rd); check("R7 pending bit", rd, 32'h80);
    check("R8 irq off without host enable", {31'h0, host_irq}, 32'h0);
    bus_write(5'h04, 32'h20);
    check("R8 irq on", {31'h0, host_irq}, 32'h1);
    bus_write(5'h10, 32'h2);
    bus_read(5'h04, rd); check("R7 masked", rd, 32'h20);
    check("R8 irq masked", {31'h0, host_irq}, 32'h0);

    // R9 configuration outputs
    bus_write(5'h04, 32'h15);
    check("R9 odd/dce/break", {28'h0, line_break, uart_en, parity_en, parity_odd}, 32'hF);
    bus_write(5'h04, 32'h0A);
    check("R9 even", {28'h0, line_break, uart_en, parity_en, parity_odd}, 32'h6);
    bus_write(5'h04, 32'h03);
    check("R9 reserved parity, disabled", {28'h0, line_break, uart_en, parity_en, parity_odd}, 32'h0);

    finish_run();
  end
endmodule